// File: doc/BRIEF.md
# Power-Good Monitor and Reboot Policy

This block watches the main power-good signals and the resume-well reset from the always-on clock domain. The supply power-good and the processor regulator power-good are each synchronized, then combined with an AND into one qualified power-good. The block adds no settling delay of its own, because the supply is expected to raise its power-good only once the rails have been stable long enough. When power-good drops while the resume reset stays deasserted, the block sets a sticky failure flag and treats the event as a partial loss. When the resume reset is asserted before power-good comes back, the event is a full power loss.

On recovery the kind of loss decides whether a restart is requested. A partial loss always produces a restart pulse. A full loss produces one only when the restart-on-loss policy input is set. A three-state machine holds the decision. Its states are POWERED, PG_LOST and FULL_FAIL. It takes these transitions: POWERED to PG_LOST on a power-good fall, PG_LOST to POWERED on a power-good rise with an unconditional restart, FULL_FAIL to POWERED on a power-good rise with a restart set by the policy, and any state to FULL_FAIL while the resume reset is asserted. The resume reset clears the block asynchronously and is released through a two-stage synchronizer.

Top module: `pwr_good_monitor`

## Requirements
- R1: `pg_ok` is high only when both `supply_pg` and `vrm_pg` are high. It follows a change on either input after two rising clock edges.
- R2: A low on either power-good input that spans at least one rising clock edge is detected as a power-good loss.
- R3: While `rsm_rst_n` is low, and after its release until power-good rises, the block reports `full_pwr_fail`=1, `pg_fail_flag`=0, `pg_ok`=0 and `reboot_req`=0.
- R4: A fall of `pg_ok` while `rsm_rst_n` is high sets `pg_fail_flag` on the next edge, and `full_pwr_fail` stays 0.
- R5: Recovery from a partial loss issues exactly one `reboot_req` pulse for either value of `restart_on_loss`.
- R6: Asserting `rsm_rst_n` low makes the loss a full failure: `full_pwr_fail` goes to 1 and `pg_fail_flag` goes to 0. On the next power-good rise, a pulse is issued only if `restart_on_loss`=1. The value 0 suppresses it.
- R7: `reboot_req` is high for exactly one cycle. It starts in the cycle after `pg_ok` first reads high.
- R8: `pg_fail_flag` stays set through recovery and clears on a one-cycle `fail_flag_clr`. If a set and a clear fall on the same edge, the set wins.
- R9: Without a power-good rise, no `reboot_req` is issued, and changes on `restart_on_loss` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on slow clock |
| supply_pg | input | 1 | Power-good from the system supply, asynchronous |
| vrm_pg | input | 1 | Power-good from the processor regulator, asynchronous |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous |
| restart_on_loss | input | 1 | 1 = restart after a full power loss |
| fail_flag_clr | input | 1 | One-cycle strobe that clears the failure flag |
| pg_ok | output | 1 | Synchronized combined power-good |
| pg_fail_flag | output | 1 | Sticky power-good failure flag |
| full_pwr_fail | output | 1 | High while in the full-failure state |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The bench sweeps every combination of these factors:
- which input drops: supply, regulator, or both;
- the policy bit;
- whether the resume reset arrives before power returns.

A design that swapped the two recovery rules would restart after a full loss with the policy off, or stay silent after a glitch. Both show up as a wrong pulse count. A design that let the clear beat a simultaneous set would lose a failure, and the bench targets that exact edge. A one-period glitch and policy toggles while powered probe for missed detections and spurious restarts.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    typedef enum logic [1:0] {
        ST_POWERED   = 2'd0,
        ST_PG_LOST   = 2'd1,
        ST_FULL_FAIL = 2'd2
    } pgm_state_e;
endpackage

// File: rtl/pgm_rst_sync.sv
module pgm_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain_q;

    // Asynchronous assert, synchronous release
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] stg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= {stg_q[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = stg_q[STAGES-1];
    end
endmodule

// File: rtl/pgm_fsm.sv
module pgm_fsm
    import pgm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    input  logic policy,
    input  logic flag_clr,
    output logic full_fail,
    output logic fail_flag,
    output logic reboot
);
    pgm_state_e state_q, state_d;
    logic       pg_d_q;
    logic       pg_rise, pg_fall;
    logic       flag_q, reboot_q;
    logic       set_flag, fire_reboot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_d_q <= 1'b0;
        else        pg_d_q <= pg_s;
    end

    assign pg_rise = pg_s & ~pg_d_q;
    assign pg_fall = ~pg_s & pg_d_q;

    // Next state and decisions
    always_comb begin
        state_d     = state_q;
        set_flag    = 1'b0;
        fire_reboot = 1'b0;
        unique case (state_q)
            ST_POWERED: begin
                if (pg_fall) begin
                    state_d  = ST_PG_LOST;
                    set_flag = 1'b1;
                end
            end
            ST_PG_LOST: begin
                if (pg_rise) begin
                    state_d     = ST_POWERED;
                    fire_reboot = 1'b1;
                end
            end
            ST_FULL_FAIL: begin
                if (pg_rise) begin
                    state_d     = ST_POWERED;
                    fire_reboot = policy;
                end
            end
            default: state_d = ST_FULL_FAIL;
        endcase
    end

    // State register: a resume reset always means full failure
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FULL_FAIL;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            reboot_q <= 1'b0;
        end else begin
            reboot_q <= fire_reboot;
            if (set_flag)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign full_fail = (state_q == ST_FULL_FAIL);
    assign fail_flag = flag_q;
    assign reboot    = reboot_q;

    a_r5_partial_reboot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PG_LOST && pg_rise) |=> reboot_q);
    a_r6_full_policy_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL_FAIL && pg_rise && !policy) |=> !reboot_q);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_rise |=> !reboot_q);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    a_r4_flag_partial: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (state_q == ST_PG_LOST));
endmodule

// File: rtl/pwr_good_monitor.sv
module pwr_good_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_aon,
    input  logic supply_pg,
    input  logic vrm_pg,
    input  logic rsm_rst_n,
    input  logic restart_on_loss,
    input  logic fail_flag_clr,
    output logic pg_ok,
    output logic pg_fail_flag,
    output logic full_pwr_fail,
    output logic reboot_req
);
    localparam int N_PG = 2;

    logic            rst_n;
    logic [N_PG-1:0] pg_sync;

    pgm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk    (clk_aon),
        .arst_n (rsm_rst_n),
        .rst_n  (rst_n)
    );

    pgm_sync #(.WIDTH(N_PG), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_aon),
        .rst_n   (rst_n),
        .d_async ({vrm_pg, supply_pg}),
        .q_sync  (pg_sync)
    );

    assign pg_ok = &pg_sync;

    pgm_fsm u_fsm (
        .clk       (clk_aon),
        .rst_n     (rst_n),
        .pg_s      (pg_ok),
        .policy    (restart_on_loss),
        .flag_clr  (fail_flag_clr),
        .full_fail (full_pwr_fail),
        .fail_flag (pg_fail_flag),
        .reboot    (reboot_req)
    );

    a_r7_single_pulse: assert property (@(posedge clk_aon) disable iff (!rst_n)
        reboot_req |=> !reboot_req);
    a_r7_after_pg_rise: assert property (@(posedge clk_aon) disable iff (!rst_n)
        reboot_req |-> (pg_ok && !$past(pg_ok, 2)));
    a_r3_fail_quiet: assert property (@(posedge clk_aon) disable iff (!rst_n)
        full_pwr_fail |-> !reboot_req);
endmodule

// File: tb/test_pwr_good_monitor.sv
module test_pwr_good_monitor;
    logic clk = 1'b0;
    logic supply_pg = 1'b0, vrm_pg = 1'b0, rsm_rst_n = 1'b0;
    logic restart_on_loss = 1'b0, fail_flag_clr = 1'b0;
    logic pg_ok, pg_fail_flag, full_pwr_fail, reboot_req;

    int n_vec = 0, n_bad = 0;
    int rb_cnt = 0, rb_run = 0, rb_max = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_good_monitor i_pwr_good_monitor (
        .clk_aon         (clk),
        .supply_pg       (supply_pg),
        .vrm_pg          (vrm_pg),
        .rsm_rst_n       (rsm_rst_n),
        .restart_on_loss (restart_on_loss),
        .fail_flag_clr   (fail_flag_clr),
        .pg_ok           (pg_ok),
        .pg_fail_flag    (pg_fail_flag),
        .full_pwr_fail   (full_pwr_fail),
        .reboot_req      (reboot_req)
    );

    always @(negedge clk) begin
        if (reboot_req) begin
            rb_cnt++;
            rb_run++;
            if (rb_run > rb_max) rb_max = rb_run;
        end else begin
            rb_run = 0;
        end
    end

    task automatic tick(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_rb();
        rb_cnt = 0;
        rb_max = 0;
    endtask

    task automatic power_up(logic pol);
        restart_on_loss = pol;
        rsm_rst_n = 1'b0;
        supply_pg = 1'b0;
        vrm_pg = 1'b0;
        tick(2);
        check("R3 full_fail in reset", full_pwr_fail, 1);
        check("R3 flag in reset", pg_fail_flag, 0);
        check("R3 pg_ok in reset", pg_ok, 0);
        rsm_rst_n = 1'b1;
        tick(4);
        check("R3 full_fail after release", full_pwr_fail, 1);
        check("R3 reboot after release", reboot_req, 0);
        clear_rb();
        supply_pg = 1'b1;
        vrm_pg = 1'b1;
        tick(1);
        check("R1 pg_ok latency", pg_ok, 0);
        tick(1);
        check("R1 pg_ok high", pg_ok, 1);
        check("R7 no pulse with pg_ok", reboot_req, 0);
        tick(1);
        check("R6/R7 power-up pulse", reboot_req, int'(pol));
        tick(1);
        check("R7 pulse width", reboot_req, 0);
        check("R6 left full_fail", full_pwr_fail, 0);
    endtask

    initial begin
        tick(1);
        for (int sel = 0; sel < 3; sel++) begin
            for (int p = 0; p < 2; p++) begin
                for (int full = 0; full < 2; full++) begin
                    power_up(logic'(p));
                    // R9: policy toggles while powered do nothing
                    clear_rb();
                    for (int t = 0; t < 4; t++) begin
                        restart_on_loss = ~restart_on_loss;
                        tick(1);
                    end
                    restart_on_loss = logic'(p);
                    check("R9 no reboot on policy toggle", rb_cnt, 0);
                    check("R9 flag unchanged", pg_fail_flag, 0);
                    // drop selected inputs
                    if (sel != 1) supply_pg = 1'b0;
                    if (sel != 0) vrm_pg = 1'b0;
                    tick(2);
                    check("R1 AND drop", pg_ok, 0);
                    if (full == 0) fail_flag_clr = 1'b1; // collides with set (R8)
                    tick(1);
                    fail_flag_clr = 1'b0;
                    check("R4 flag set", pg_fail_flag, 1);
                    check("R4 not full", full_pwr_fail, 0);
                    if (full != 0) begin
                        rsm_rst_n = 1'b0;
                        tick(1);
                        check("R6 full_fail on reset", full_pwr_fail, 1);
                        check("R6 flag cleared", pg_fail_flag, 0);
                        rsm_rst_n = 1'b1;
                        tick(4);
                    end
                    clear_rb();
                    supply_pg = 1'b1;
                    vrm_pg = 1'b1;
                    tick(6);
                    if (full != 0) check("R6 policy reboot", rb_cnt, p);
                    else           check("R5 partial reboot", rb_cnt, 1);
                    check("R7 max width", rb_max, (full != 0 && p == 0) ? 0 : 1);
                    check("R8 flag sticky", pg_fail_flag, (full != 0) ? 0 : 1);
                    fail_flag_clr = 1'b1;
                    tick(1);
                    fail_flag_clr = 1'b0;
                    check("R8 flag cleared", pg_fail_flag, 0);
                end
            end
        end
        // R2: one-period glitch on the regulator input
        power_up(1'b0);
        clear_rb();
        vrm_pg = 1'b0;
        tick(1);
        vrm_pg = 1'b1;
        tick(6);
        check("R2 glitch flag", pg_fail_flag, 1);
        check("R2/R5 glitch reboot", rb_cnt, 1);
        check("R2 not full", full_pwr_fail, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule